// File: doc/BRIEF.md
# SPI Port with Per-Word Request Handshake

This block is a serial port that can act either as the clocked side (slave) or the clocking side (master) of an SPI link. It uses SPI mode 0: SCK idles low, data is sampled on the rising edge and changed on the falling edge, and words go most significant bit first. The word width is a parameter and defaults to 8. On the host side there is a parallel word interface: the host writes a transmit word, reads a receive word with a valid flag, and sets a small configuration made of a role bit, two request-enable bits and an SCK divider.

Word traffic is paced by an active-low request line, and the direction of that line follows the role. As a slave, the block drives the line low when a fresh transmit word is waiting. It releases the line on the first SCK rising edge of the word that carries that data. As a master, the block samples the line from the remote device and starts exactly one word for each new assertion, provided a transmit word is pending. It then waits for the line to be released and asserted again before it starts another word.

The slave-select input enables the slave path. In master mode the same input is watched for misuse: seeing it asserted raises a sticky bus-error flag. The incoming SCK, MOSI, slave-select and request signals are brought into the system clock through two-flop synchronizers.

Top module: `spi_req_port`

## Requirements
- R1: In slave mode with `ss_n_in` high, SCK edges are ignored: no bit is shifted, no word completes, the request line is not released, and `miso_oe` stays 0. `miso_oe` is 1 only when the role is slave and `ss_n_in` was low two clocks earlier.
- R2: In slave mode with `ss_n_in` low, each word of `W` bits is captured from MOSI on the SCK rising edges, MSB first, into `rx_data`. Over the same word, MISO presents the transmit word MSB first. Back-to-back words with `ss_n_in` held low reload the transmit word after the last bit.
- R3: In slave mode (`cfg_master`=0) with `cfg_req_en` nonzero, `req_n_out` goes low in the clock after a `tx_write` pulse and goes high again on the first SCK rising edge of the next word.
- R4: In master mode (`cfg_master`=1) `sck_oe` is 1 and SCK stays low until a transmit word is pending and `req_n_in` is low. Once a word starts, each SCK half period lasts `clk_div`+1 system clocks.
- R5: After a master word completes, no new word starts while `req_n_in` stays low, even with a word pending. A new word starts only after `req_n_in` has gone high and then low again.
- R6: `bus_err` becomes 1 when `ss_n_in` is seen low in master mode. It then stays 1 until a one is written on `err_clr`, with a set taking priority over a clear in the same clock.
- R7: `req_oe` is 0 during reset, in master mode, and when both bits of `cfg_req_en` are 0. Otherwise it is 1.
- R8: `rx_valid` rises when a word completes in either role and stays high until an `rx_read` pulse.
- R9: In master mode, MOSI carries the pending transmit word MSB first. The word sampled from MISO on the SCK rising edges appears in `rx_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_master | input | 1 | Role select: 1 master, 0 slave |
| cfg_req_en | input | 2 | Request pin enables; both 0 tri-states the pin |
| clk_div | input | DIVW | Master SCK half period minus one, in system clocks |
| tx_write | input | 1 | Load pulse for `tx_data` |
| tx_data | input | W | Transmit word |
| rx_read | input | 1 | Clears `rx_valid` |
| rx_data | output | W | Last received word |
| rx_valid | output | 1 | Receive word available |
| err_clr | input | 1 | Write-one-to-clear for `bus_err` |
| bus_err | output | 1 | Sticky slave-select misuse flag |
| sck_in | input | 1 | SCK from the remote master (slave mode) |
| sck_out | output | 1 | Generated SCK (master mode) |
| sck_oe | output | 1 | SCK output enable |
| mosi_in | input | 1 | Serial data in (slave mode) |
| mosi_out | output | 1 | Serial data out (master mode) |
| miso_in | input | 1 | Serial data in (master mode) |
| miso_out | output | 1 | Serial data out (slave mode) |
| miso_oe | output | 1 | MISO output enable |
| ss_n_in | input | 1 | Active-low slave select |
| req_n_in | input | 1 | Request line from the remote slave (master mode) |
| req_n_out | output | 1 | Request line driven low when ready (slave mode) |
| req_oe | output | 1 | Request pin output enable |

## Verification
If the bit counter is off by one, the whole received word shifts by a bit, so `rx_data` is wrong as soon as the first word ends. The request flag or the arming state of the master shows up directly on the pins: a request that is released too early or too late, or a master word that starts while `req_n_in` is still held low, is visible within one bit time. The bus-error and request-enable state is compared against a reference model on every clock, so a wrong set, clear or priority is caught in the clock where it occurs.

// File: rtl/spi_req_pkg.sv
package spi_req_pkg;

    typedef enum logic {
        ROLE_SLAVE  = 1'b0,
        ROLE_MASTER = 1'b1
    } role_e;

    typedef enum logic {
        MST_IDLE = 1'b0,
        MST_RUN  = 1'b1
    } mst_state_e;

    typedef struct packed {
        role_e      role;
        logic [1:0] req_en;
    } port_cfg_t;

    localparam port_cfg_t CFG_RESET = '{role: ROLE_SLAVE, req_en: 2'b00};

    // asynchronous pins brought into the system clock
    typedef struct packed {
        logic req_n;
        logic ss_n;
        logic mosi;
        logic sck;
    } pin_vec_t;

    localparam pin_vec_t PIN_IDLE = '{req_n: 1'b1, ss_n: 1'b1, mosi: 1'b0, sck: 1'b0};

    function automatic logic req_pin_driven(input port_cfg_t c);
        return (c.role == ROLE_SLAVE) && (c.req_en != 2'b00);
    endfunction

endpackage

// File: rtl/spi_req_sync.sv
module spi_req_sync #(
    parameter int N = 4,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);

    generate
        for (genvar i = 0; i < N; i++) begin : g_bit
            logic [1:0] stages;
            always_ff @(posedge clk) begin
                if (rst) stages <= {2{RST_VAL[i]}};
                else     stages <= {stages[0], d[i]};
            end
            assign q[i] = stages[1];
        end
    endgenerate

endmodule

// File: rtl/spi_req_slave.sv
module spi_req_slave #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         ss_act,
    input  logic         ss_start,
    input  logic         sck_rise,
    input  logic         sck_fall,
    input  logic         mosi_bit,
    input  logic [W-1:0] tx_word,
    output logic         miso_bit,
    output logic         first_rise,
    output logic         word_done,
    output logic [W-1:0] rx_word
);

    localparam int CW = (W > 2) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    logic [W-1:0]  sr;
    logic          samp;
    logic          reload;
    logic [CW-1:0] cnt;
    logic          live;

    assign live       = en & ss_act & ~ss_start;
    assign first_rise = live & sck_rise & (cnt == '0);
    assign word_done  = live & sck_rise & (cnt == LAST);
    assign rx_word    = {sr[W-2:0], mosi_bit};
    assign miso_bit   = sr[W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            sr     <= '0;
            samp   <= 1'b0;
            reload <= 1'b0;
            cnt    <= '0;
        end else if (!en || !ss_act) begin
            cnt    <= '0;
            reload <= 1'b0;
        end else if (ss_start) begin
            sr     <= tx_word;
            cnt    <= '0;
            reload <= 1'b0;
        end else if (sck_rise) begin
            samp <= mosi_bit;
            if (cnt == LAST) begin
                cnt    <= '0;
                reload <= 1'b1;
            end else begin
                cnt <= cnt + CW'(1);
            end
        end else if (sck_fall) begin
            if (reload) begin
                sr     <= tx_word;
                reload <= 1'b0;
            end else begin
                sr <= {sr[W-2:0], samp};
            end
        end
    end

endmodule

// File: rtl/spi_req_master.sv
module spi_req_master
    import spi_req_pkg::*;
#(
    parameter int W    = 8,
    parameter int DIVW = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            en,
    input  logic            start,
    input  logic [DIVW-1:0] div,
    input  logic [W-1:0]    tx_word,
    input  logic            miso_bit,
    output logic            sck,
    output logic            mosi_bit,
    output logic            busy,
    output logic            word_done,
    output logic [W-1:0]    rx_word
);

    localparam int CW = (W > 2) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    mst_state_e      st;
    logic [DIVW-1:0] hc;
    logic [W-1:0]    sr;
    logic            samp;
    logic [CW-1:0]   bits;
    logic            tick;

    assign tick      = (st == MST_RUN) && (hc == div);
    assign word_done = tick & sck & (bits == LAST);
    assign rx_word   = {sr[W-2:0], samp};
    assign mosi_bit  = sr[W-1];
    assign busy      = (st == MST_RUN);

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= MST_IDLE;
            hc   <= '0;
            sck  <= 1'b0;
            sr   <= '0;
            samp <= 1'b0;
            bits <= '0;
        end else if (!en) begin
            st   <= MST_IDLE;
            hc   <= '0;
            sck  <= 1'b0;
            bits <= '0;
        end else begin
            case (st)
                MST_IDLE: begin
                    if (start) begin
                        sr   <= tx_word;
                        st   <= MST_RUN;
                        hc   <= '0;
                        bits <= '0;
                        sck  <= 1'b0;
                    end
                end
                default: begin
                    if (tick) begin
                        hc  <= '0;
                        sck <= ~sck;
                        if (!sck) begin
                            samp <= miso_bit;
                        end else begin
                            sr <= {sr[W-2:0], samp};
                            if (bits == LAST) st <= MST_IDLE;
                            else              bits <= bits + CW'(1);
                        end
                    end else begin
                        hc <= hc + DIVW'(1);
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/spi_req_port.sv
module spi_req_port
    import spi_req_pkg::*;
#(
    parameter int W    = 8,
    parameter int DIVW = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cfg_master,
    input  logic [1:0]      cfg_req_en,
    input  logic [DIVW-1:0] clk_div,
    input  logic            tx_write,
    input  logic [W-1:0]    tx_data,
    input  logic            rx_read,
    output logic [W-1:0]    rx_data,
    output logic            rx_valid,
    input  logic            err_clr,
    output logic            bus_err,
    input  logic            sck_in,
    output logic            sck_out,
    output logic            sck_oe,
    input  logic            mosi_in,
    output logic            mosi_out,
    input  logic            miso_in,
    output logic            miso_out,
    output logic            miso_oe,
    input  logic            ss_n_in,
    input  logic            req_n_in,
    output logic            req_n_out,
    output logic            req_oe
);

    port_cfg_t   cfg_q;
    pin_vec_t    pins_raw;
    pin_vec_t    pins_s;
    logic        sck_d;
    logic        ss_d;
    logic [W-1:0] tx_buf;
    logic        tx_full;
    logic        armed;
    logic        slave_en;
    logic        master_en;

    logic        slv_first;
    logic        slv_done;
    logic [W-1:0] slv_rx;
    logic        slv_miso;

    logic        mst_start;
    logic        mst_busy;
    logic        mst_done;
    logic        mst_sck;
    logic        mst_mosi;
    logic [W-1:0] mst_rx;

    always_ff @(posedge clk) begin
        if (rst) cfg_q <= CFG_RESET;
        else     cfg_q <= '{role: role_e'(cfg_master), req_en: cfg_req_en};
    end

    assign slave_en  = (cfg_q.role == ROLE_SLAVE);
    assign master_en = (cfg_q.role == ROLE_MASTER);

    assign pins_raw = '{req_n: req_n_in, ss_n: ss_n_in, mosi: mosi_in, sck: sck_in};

    spi_req_sync #(.N(4), .RST_VAL(PIN_IDLE)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pins_raw),
        .q   (pins_s)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_d <= 1'b0;
            ss_d  <= 1'b1;
        end else begin
            sck_d <= pins_s.sck;
            ss_d  <= pins_s.ss_n;
        end
    end

    spi_req_slave #(.W(W)) u_slave (
        .clk        (clk),
        .rst        (rst),
        .en         (slave_en),
        .ss_act     (~pins_s.ss_n),
        .ss_start   (ss_d & ~pins_s.ss_n),
        .sck_rise   (pins_s.sck & ~sck_d),
        .sck_fall   (~pins_s.sck & sck_d),
        .mosi_bit   (pins_s.mosi),
        .tx_word    (tx_buf),
        .miso_bit   (slv_miso),
        .first_rise (slv_first),
        .word_done  (slv_done),
        .rx_word    (slv_rx)
    );

    assign mst_start = master_en & tx_full & ~pins_s.req_n & armed & ~mst_busy;

    spi_req_master #(.W(W), .DIVW(DIVW)) u_master (
        .clk       (clk),
        .rst       (rst),
        .en        (master_en),
        .start     (mst_start),
        .div       (clk_div),
        .tx_word   (tx_buf),
        .miso_bit  (miso_in),
        .sck       (mst_sck),
        .mosi_bit  (mst_mosi),
        .busy      (mst_busy),
        .word_done (mst_done),
        .rx_word   (mst_rx)
    );

    // transmit holding word and its ready/pending flag
    always_ff @(posedge clk) begin
        if (rst) begin
            tx_buf  <= '0;
            tx_full <= 1'b0;
        end else if (tx_write) begin
            tx_buf  <= tx_data;
            tx_full <= 1'b1;
        end else if ((slave_en && slv_first) || mst_start) begin
            tx_full <= 1'b0;
        end
    end

    // master re-arms only after the request line is released
    always_ff @(posedge clk) begin
        if (rst)               armed <= 1'b1;
        else if (mst_start)    armed <= 1'b0;
        else if (pins_s.req_n) armed <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_data  <= '0;
            rx_valid <= 1'b0;
        end else if (slv_done || mst_done) begin
            rx_data  <= slv_done ? slv_rx : mst_rx;
            rx_valid <= 1'b1;
        end else if (rx_read) begin
            rx_valid <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) bus_err <= 1'b0;
        else     bus_err <= (bus_err & ~err_clr) | (master_en & ~pins_s.ss_n);
    end

    assign sck_out   = mst_sck;
    assign sck_oe    = ~rst & master_en;
    assign mosi_out  = mst_mosi;
    assign miso_out  = slv_miso;
    assign miso_oe   = ~rst & slave_en & ~pins_s.ss_n;
    assign req_n_out = ~tx_full;
    assign req_oe    = ~rst & req_pin_driven(cfg_q);

endmodule

// File: rtl/spi_req_port_chk.sv
module spi_req_port_chk (
    input logic clk,
    input logic rst,
    input logic cfg_master,
    input logic tx_write,
    input logic rx_read,
    input logic err_clr,
    input logic ss_n_in,
    input logic req_oe,
    input logic req_n_out,
    input logic miso_oe,
    input logic rx_valid,
    input logic bus_err,
    input logic sck_oe
);

    // R1
    miso_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        miso_oe |-> !$past(ss_n_in, 2));

    // R3
    req_from_write_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(req_n_out) |-> $past(tx_write));

    // R4
    sck_drive_role_chk: assert property (@(posedge clk) disable iff (rst)
        sck_oe |-> $past(cfg_master));

    // R6
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_err && !err_clr) |=> bus_err);

    // R7
    req_input_role_chk: assert property (@(posedge clk) disable iff (rst)
        $past(cfg_master) |-> !req_oe);

    // R8
    rx_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && !rx_read) |=> rx_valid);

endmodule

bind spi_req_port spi_req_port_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .cfg_master (cfg_master),
    .tx_write   (tx_write),
    .rx_read    (rx_read),
    .err_clr    (err_clr),
    .ss_n_in    (ss_n_in),
    .req_oe     (req_oe),
    .req_n_out  (req_n_out),
    .miso_oe    (miso_oe),
    .rx_valid   (rx_valid),
    .bus_err    (bus_err),
    .sck_oe     (sck_oe)
);

// File: tb/spi_req_port_tb.sv
module spi_req_port_tb;

    localparam int W    = 8;
    localparam int DIVW = 8;
    localparam int DIV  = 3;

    logic            clk;
    logic            rst;
    logic            cfg_master;
    logic [1:0]      cfg_req_en;
    logic [DIVW-1:0] clk_div;
    logic            tx_write;
    logic [W-1:0]    tx_data;
    logic            rx_read;
    logic [W-1:0]    rx_data;
    logic            rx_valid;
    logic            err_clr;
    logic            bus_err;
    logic            sck_in, sck_out, sck_oe;
    logic            mosi_in, mosi_out;
    logic            miso_in, miso_out, miso_oe;
    logic            ss_n_in;
    logic            req_n_in, req_n_out, req_oe;

    int tests = 0;
    int fails = 0;

    spi_req_port #(.W(W), .DIVW(DIVW)) u_dut (
        .clk(clk), .rst(rst), .cfg_master(cfg_master), .cfg_req_en(cfg_req_en),
        .clk_div(clk_div), .tx_write(tx_write), .tx_data(tx_data),
        .rx_read(rx_read), .rx_data(rx_data), .rx_valid(rx_valid),
        .err_clr(err_clr), .bus_err(bus_err),
        .sck_in(sck_in), .sck_out(sck_out), .sck_oe(sck_oe),
        .mosi_in(mosi_in), .mosi_out(mosi_out),
        .miso_in(miso_in), .miso_out(miso_out), .miso_oe(miso_oe),
        .ss_n_in(ss_n_in), .req_n_in(req_n_in), .req_n_out(req_n_out), .req_oe(req_oe)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic waitc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic tx_pulse(input logic [W-1:0] v);
        tx_data  = v;
        tx_write = 1'b1;
        waitc(1);
        tx_write = 1'b0;
    endtask

    task automatic rd_pulse();
        rx_read = 1'b1;
        waitc(1);
        rx_read = 1'b0;
    endtask

    // behavioural model of the error flag and the request pin enable
    logic       m_mq, m_e, m_s1, m_s2, m_live;
    logic [1:0] m_en;
    initial m_live = 1'b0;

    always @(posedge clk) begin
        if (rst) begin
            m_e = 1'b0; m_s1 = 1'b1; m_s2 = 1'b1; m_mq = 1'b0; m_en = 2'b00;
        end else begin
            m_e  = (m_e & ~err_clr) | (m_mq & ~m_s2);
            m_s2 = m_s1;
            m_s1 = ss_n_in;
            m_mq = cfg_master;
            m_en = cfg_req_en;
        end
        m_live = 1'b1;
    end

    always @(negedge clk) begin
        if (m_live) begin
            chk("R6 error flag vs model", bus_err, m_e);
            chk("R7 request enable vs model", req_oe, (!rst && !m_mq && m_en != 2'b00));
        end
    end

    // count master SCK rising edges seen at the pins
    int   rise_cnt = 0;
    logic sck_seen = 1'b0;
    always @(negedge clk) begin
        if (sck_out === 1'b1 && sck_seen === 1'b0) rise_cnt++;
        sck_seen = sck_out;
    end

    task automatic slv_word(input logic [W-1:0] mw, input logic [W-1:0] exp_miso,
                            input bit wr, input logic [W-1:0] nxt);
        logic [W-1:0] got = '0;
        for (int i = 0; i < W; i++) begin
            mosi_in = mw[W-1-i];
            waitc(8);
            got = {got[W-2:0], miso_out};
            sck_in = 1'b1;
            waitc(8);
            if (i == 0) chk("R3 request released on first SCK rise", req_n_out, 1);
            if (i == 2 && wr) begin
                tx_pulse(nxt);
                chk("R3 request asserted after write", req_n_out, 0);
            end
            sck_in = 1'b0;
            waitc(8);
        end
        chk("R2 slave MISO word", got, exp_miso);
        chk("R2 slave received word", rx_data, mw);
        chk("R8 valid after slave word", rx_valid, 1);
    endtask

    task automatic mst_word(input logic [W-1:0] exp_mosi, input logic [W-1:0] mw);
        logic [W-1:0] got = '0;
        int   idx = 0;
        int   hi = 0;
        int   guard = 0;
        logic prev = 1'b0;
        miso_in  = mw[W-1];
        req_n_in = 1'b0;
        while (idx < W && guard < 5000) begin
            @(negedge clk);
            guard++;
            if (sck_out) hi++;
            if (sck_out && !prev) got = {got[W-2:0], mosi_out};
            if (!sck_out && prev) begin
                if (idx == 0) chk("R4 SCK high time", hi, DIV + 1);
                hi = 0;
                idx++;
                if (idx < W) miso_in = mw[W-1-idx];
            end
            prev = sck_out;
        end
        chk("R9 master MOSI word", got, exp_mosi);
        waitc(1);
        chk("R9 master received word", rx_data, mw);
        chk("R8 valid after master word", rx_valid, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog (all requirements): actual hung expected finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int base;
        rst = 1'b1; cfg_master = 1'b0; cfg_req_en = 2'b00; clk_div = DIVW'(DIV);
        tx_write = 1'b0; tx_data = '0; rx_read = 1'b0; err_clr = 1'b0;
        sck_in = 1'b0; mosi_in = 1'b0; miso_in = 1'b0; ss_n_in = 1'b1; req_n_in = 1'b1;
        waitc(4);
        chk("R7 request tri-stated in reset", req_oe, 0);
        chk("R1 MISO off in reset", miso_oe, 0);
        chk("R8 no valid in reset", rx_valid, 0);
        chk("R6 no error in reset", bus_err, 0);
        rst = 1'b0;
        waitc(3);
        chk("R7 both enables clear", req_oe, 0);
        cfg_req_en = 2'b10;
        waitc(2);
        chk("R7 request driven in slave", req_oe, 1);
        chk("R3 request idle before write", req_n_out, 1);
        tx_pulse(8'hA5);
        chk("R3 request asserted after write", req_n_out, 0);

        // clocks with slave select high must be ignored
        mosi_in = 1'b1;
        for (int k = 0; k < W; k++) begin
            sck_in = 1'b1; waitc(8);
            sck_in = 1'b0; waitc(8);
        end
        chk("R1 no word while deselected", rx_valid, 0);
        chk("R1 MISO off while deselected", miso_oe, 0);
        chk("R1 request kept while deselected", req_n_out, 0);

        ss_n_in = 1'b0;
        waitc(8);
        chk("R1 MISO driven when selected", miso_oe, 1);
        slv_word(8'h3C, 8'hA5, 1'b1, 8'h5A);
        rd_pulse();
        chk("R8 valid cleared by read", rx_valid, 0);
        slv_word(8'hC3, 8'h5A, 1'b0, 8'h00);
        ss_n_in = 1'b1;
        waitc(4);
        chk("R1 MISO off after deselect", miso_oe, 0);
        rd_pulse();

        // master role
        cfg_master = 1'b1;
        waitc(2);
        chk("R7 request pin input in master", req_oe, 0);
        chk("R4 SCK driven in master", sck_oe, 1);
        base = rise_cnt;
        tx_pulse(8'h96);
        waitc(40);
        chk("R4 no SCK without request", rise_cnt - base, 0);
        mst_word(8'h96, 8'h69);

        rd_pulse();
        tx_pulse(8'h0F);
        base = rise_cnt;
        waitc(100);
        chk("R5 held request starts nothing", rise_cnt - base, 0);
        chk("R5 no word while request held", rx_valid, 0);
        req_n_in = 1'b1;
        waitc(4);
        mst_word(8'h0F, 8'hF0);

        // slave select misuse in master mode
        chk("R6 no error before misuse", bus_err, 0);
        ss_n_in = 1'b0;
        waitc(4);
        chk("R6 error raised", bus_err, 1);
        ss_n_in = 1'b1;
        waitc(6);
        chk("R6 error sticky", bus_err, 1);
        err_clr = 1'b1;
        waitc(1);
        err_clr = 1'b0;
        waitc(1);
        chk("R6 error cleared", bus_err, 0);

        waitc(4);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule